// File: doc/BRIEF.md
# Floppy Controller Host Register Block

This block is the processor-facing front of a floppy disk controller. It sits on an 8-bit memory-mapped bus and decodes a 16-byte address window. That window holds five things: a write-only drive control byte, a command/status location that behaves differently for writes and reads, and three working registers for the track number, the sector number and the data byte. A separate command engine handles head motion, disk serialization and CRC. Here it is represented only by ports: it receives a one-cycle command strobe with the command byte, and it supplies the status byte. It can also overwrite the track register after a seek, and it can load the data register with a byte read from the disk.

The control byte is kept inside the block and cannot be read back. Its three low bits select a drive, and any nonzero value switches the spindle motor on. Selecting a different drive does not change the track register, because the head of the newly selected drive may sit at another cylinder. Software must therefore reload the track register. A sticky flag marks that the track register may be stale until the host does this.

Top module: `fdc_host_regs`

## Requirements
- R1: While reset is low and right after reset, motorOn, driveSel, driveChanged and cmdValid are 0, and trackOut, sectorOut and dataOut are 0x00.
- R2: A host write to offset 0x8 makes cmdValid high for the cycle after the write edge, with cmdByte equal to the written byte. A write to any other offset leaves cmdValid low.
- R3: A host read of offset 0x8 returns engStatus in the same cycle, combinationally.
- R4: Host reads of offsets 0x0 through 0x7 and 0xC through 0xF return 0x00, whatever was last written to the control byte at 0x0.
- R5: After a write to offset 0x0, motorOn is 0 if the written byte is 0x00 and 1 for any other byte.
- R6: driveSel follows bits 2:0 of the last byte written to offset 0x0.
- R7: The track register at 0x9 is loaded by a host write or by engTrackWe. If both occur in the same cycle, the host value wins. Reads of 0x9 and trackOut show the register.
- R8: The sector register at 0xA is loaded only by host writes. Reads of 0xA and sectorOut show it.
- R9: The data register at 0xB is loaded by a host write or by engDataWe, with the host winning a same-cycle conflict. Reads of 0xB and dataOut show it.
- R10: A control write that changes bits 2:0 sets driveChanged and leaves the track register unchanged. A control write that keeps bits 2:0 leaves driveChanged as it was. A host write to 0x9 clears driveChanged, and an engine track load does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register offset in the window |
| busWrEn | input | 1 | Host write strobe for this cycle |
| busRdEn | input | 1 | Host read strobe for this cycle |
| busWrData | input | 8 | Host write byte |
| busRdData | output | 8 | Host read byte (0x00 when no read is active) |
| engStatus | input | 8 | Status byte from the command engine |
| engTrackWe | input | 1 | Engine loads the track register |
| engTrackData | input | 8 | Track value from the engine |
| engDataWe | input | 1 | Engine loads the data register |
| engDataIn | input | 8 | Data byte from the engine |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdByte | output | 8 | Last command byte written |
| trackOut | output | 8 | Track register |
| sectorOut | output | 8 | Sector register |
| dataOut | output | 8 | Data register |
| motorOn | output | 1 | Spindle motor enable |
| driveSel | output | 3 | Drive select bits |
| driveChanged | output | 1 | Track register may be stale |

## Verification
The assertions assume that the host issues at most one access per cycle. They also assume that busAddr and busWrData are stable and known whenever a strobe is high. The engine strobes may coincide with a host write, and priority covers that case. The random stimulus never raises busWrEn and busRdEn together. It changes the address and data only at the falling edge. It forces engine and host collisions only in the directed priority cases.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_CMD    = 8;
  localparam int OFS_TRACK  = 9;
  localparam int OFS_SECTOR = 10;
  localparam int OFS_DATA   = 11;

  typedef struct packed {
    logic wrCtrl;
    logic wrCmd;
    logic wrTrack;
    logic wrSector;
    logic wrData;
  } regStrobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STATUS,
    RD_TRACK,
    RD_SECTOR,
    RD_DATA
  } rdSel_t;
endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode
  import fdc_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_TRACK  = ADDR_W'(OFS_TRACK);
  localparam logic [ADDR_W-1:0] A_SECTOR = ADDR_W'(OFS_SECTOR);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);

  always_comb begin
    strobe          = '0;
    strobe.wrCtrl   = busWrEn && (busAddr == A_CTRL);
    strobe.wrCmd    = busWrEn && (busAddr == A_CMD);
    strobe.wrTrack  = busWrEn && (busAddr == A_TRACK);
    strobe.wrSector = busWrEn && (busAddr == A_SECTOR);
    strobe.wrData   = busWrEn && (busAddr == A_DATA);
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (busRdEn) begin
      unique case (busAddr)
        A_CMD:    rdSel = RD_STATUS;
        A_TRACK:  rdSel = RD_TRACK;
        A_SECTOR: rdSel = RD_SECTOR;
        A_DATA:   rdSel = RD_DATA;
        default:  rdSel = RD_ZERO;
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R2

  AST_CTRL_NEVER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_CTRL) |-> rdSel == RD_ZERO); // R4
endmodule

// File: rtl/fdc_host_dp.sv
module fdc_host_dp
  import fdc_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] engStatus,
  input  logic              engTrackWe,
  input  logic [DATA_W-1:0] engTrackData,
  input  logic              engDataWe,
  input  logic [DATA_W-1:0] engDataIn,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic [DATA_W-1:0] trackOut,
  output logic [DATA_W-1:0] sectorOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              motorOn,
  output logic [SEL_W-1:0]  driveSel,
  output logic              driveChanged
);
  logic [DATA_W-1:0] ctrlReg, trackReg, sectorReg, dataReg, cmdReg;
  logic              cmdPulse, staleFlag;
  logic              selDiffers;

  assign selDiffers = busWrData[SEL_W-1:0] != ctrlReg[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      trackReg  <= '0;
      sectorReg <= '0;
      dataReg   <= '0;
      cmdReg    <= '0;
      cmdPulse  <= 1'b0;
      staleFlag <= 1'b0;
    end else begin
      cmdPulse <= strobe.wrCmd;
      if (strobe.wrCmd)    cmdReg    <= busWrData;
      if (strobe.wrCtrl)   ctrlReg   <= busWrData;
      if (strobe.wrSector) sectorReg <= busWrData;
      if (strobe.wrTrack)  trackReg  <= busWrData;
      else if (engTrackWe) trackReg  <= engTrackData;
      if (strobe.wrData)   dataReg   <= busWrData;
      else if (engDataWe)  dataReg   <= engDataIn;
      if (strobe.wrTrack)                     staleFlag <= 1'b0;
      else if (strobe.wrCtrl && selDiffers)   staleFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: busRdData = engStatus;
      RD_TRACK:  busRdData = trackReg;
      RD_SECTOR: busRdData = sectorReg;
      RD_DATA:   busRdData = dataReg;
      default:   busRdData = '0;
    endcase
  end

  assign cmdValid     = cmdPulse;
  assign cmdByte      = cmdReg;
  assign trackOut     = trackReg;
  assign sectorOut    = sectorReg;
  assign dataOut      = dataReg;
  assign motorOn      = |ctrlReg;
  assign driveSel     = ctrlReg[SEL_W-1:0];
  assign driveChanged = staleFlag;

  AST_MOTOR_OFF_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && busWrData == '0) |=> !motorOn); // R5

  AST_MOTOR_ON_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && busWrData != '0) |=> motorOn); // R5

  AST_SELECT_KEEPS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && !engTrackWe) |=> $stable(trackOut)); // R10

  AST_TRACK_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTrack |=> !driveChanged); // R10

  AST_HOST_TRACK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTrack |=> trackOut == $past(busWrData)); // R7

  AST_HOST_DATA_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> dataOut == $past(busWrData)); // R9
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_host_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] engStatus,
  input  logic              engTrackWe,
  input  logic [DATA_W-1:0] engTrackData,
  input  logic              engDataWe,
  input  logic [DATA_W-1:0] engDataIn,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic [DATA_W-1:0] trackOut,
  output logic [DATA_W-1:0] sectorOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              motorOn,
  output logic [SEL_W-1:0]  driveSel,
  output logic              driveChanged
);
  regStrobe_t strobe;
  rdSel_t     rdSel;

  fdc_host_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strobe(strobe), .rdSel(rdSel)
  );

  fdc_host_dp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .busWrData(busWrData), .busRdData(busRdData), .engStatus(engStatus),
    .engTrackWe(engTrackWe), .engTrackData(engTrackData),
    .engDataWe(engDataWe), .engDataIn(engDataIn), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .trackOut(trackOut), .sectorOut(sectorOut),
    .dataOut(dataOut), .motorOn(motorOn), .driveSel(driveSel),
    .driveChanged(driveChanged)
  );

  AST_CMD_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(busWrEn && busAddr == ADDR_W'(OFS_CMD))); // R2

  AST_CMD_PULSE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_CMD)) |=> (cmdValid && cmdByte == $past(busWrData))); // R2

  AST_STATUS_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(OFS_CMD)) |-> busRdData == engStatus); // R3
endmodule

// File: tb/fdc_host_regs_tb.sv
module fdc_host_regs_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] busAddr;
  logic       busWrEn, busRdEn;
  logic [7:0] busWrData, busRdData, engStatus, engTrackData, engDataIn;
  logic       engTrackWe, engDataWe;
  logic       cmdValid, motorOn, driveChanged;
  logic [7:0] cmdByte, trackOut, sectorOut, dataOut;
  logic [2:0] driveSel;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [7:0] mCtrl, mTrack, mSector, mData;
  logic       mStale;

  always #4 clk = ~clk;

  fdc_host_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .engStatus(engStatus), .engTrackWe(engTrackWe), .engTrackData(engTrackData),
    .engDataWe(engDataWe), .engDataIn(engDataIn), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .trackOut(trackOut), .sectorOut(sectorOut),
    .dataOut(dataOut), .motorOn(motorOn), .driveSel(driveSel),
    .driveChanged(driveChanged)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    case (a)
      4'h8:    return engStatus;
      4'h9:    return mTrack;
      4'hA:    return mSector;
      4'hB:    return mData;
      default: return 8'h00;
    endcase
  endfunction

  task automatic checkState();
    chk("R5 motorOn", {7'b0, motorOn}, {7'b0, mCtrl != 8'h00});
    chk("R6 driveSel", {5'b0, driveSel}, {5'b0, mCtrl[2:0]});
    chk("R7 trackOut", trackOut, mTrack);
    chk("R8 sectorOut", sectorOut, mSector);
    chk("R9 dataOut", dataOut, mData);
    chk("R10 driveChanged", {7'b0, driveChanged}, {7'b0, mStale});
  endtask

  // host write, optionally with an engine load in the same cycle
  task automatic cycleOp(input bit hostW, input logic [3:0] a, input logic [7:0] d,
                         input bit eTrk, input logic [7:0] t,
                         input bit eDat, input logic [7:0] e);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = hostW;
    engTrackWe = eTrk; engTrackData = t; engDataWe = eDat; engDataIn = e;
    @(negedge clk);
    busWrEn = 1'b0; engTrackWe = 1'b0; engDataWe = 1'b0;
    if (hostW) begin
      case (a)
        4'h0: begin
          if (d[2:0] != mCtrl[2:0]) mStale = 1'b1;
          mCtrl = d;
        end
        4'h9: begin mTrack = d; mStale = 1'b0; end
        4'hA: mSector = d;
        4'hB: mData = d;
        default: ;
      endcase
    end
    if (eTrk && !(hostW && a == 4'h9)) mTrack = t;
    if (eDat && !(hostW && a == 4'hB)) mData = e;
    if (hostW && a == 4'h8) begin
      chk("R2 cmdValid", {7'b0, cmdValid}, 8'h01);
      chk("R2 cmdByte", cmdByte, d);
    end else begin
      chk("R2 cmdValid idle", {7'b0, cmdValid}, 8'h00);
    end
    checkState();
  endtask

  task automatic hostRd(input logic [3:0] a);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    if (a == 4'h8) chk("R3 status read", busRdData, expRead(a));
    else if (a < 4'h8 || a > 4'hB) chk("R4 hidden read", busRdData, expRead(a));
    else chk("R7/R8/R9 register read", busRdData, expRead(a));
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1793));
    rstN = 1'b0; busAddr = '0; busWrEn = 0; busRdEn = 0; busWrData = '0;
    engStatus = 8'h5A; engTrackWe = 0; engTrackData = '0; engDataWe = 0; engDataIn = '0;
    mCtrl = '0; mTrack = '0; mSector = '0; mData = '0; mStale = 0;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1 cmdValid", {7'b0, cmdValid}, 8'h00);
    checkState();
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cmdValid", {7'b0, cmdValid}, 8'h00);
    checkState();

    // directed corner cases
    cycleOp(1, 4'h0, 8'h00, 0, 0, 0, 0);          // R5 zero keeps motor off
    cycleOp(1, 4'h0, 8'h80, 0, 0, 0, 0);          // R5 nonzero with sel 0 -> motor on, no change R10
    hostRd(4'h0);                                  // R4 control not readable
    cycleOp(1, 4'h9, 8'd10, 0, 0, 0, 0);          // R7 host track
    cycleOp(1, 4'h0, 8'h02, 0, 0, 0, 0);          // R10 select change, track stays 10
    cycleOp(0, 4'h0, 8'h00, 1, 8'd23, 0, 0);      // R10 engine load keeps flag
    cycleOp(1, 4'h9, 8'd23, 0, 0, 0, 0);          // R10 host write clears flag
    cycleOp(1, 4'h9, 8'h33, 1, 8'h44, 0, 0);      // R7 host wins
    cycleOp(1, 4'hB, 8'h55, 0, 0, 1, 8'h66);      // R9 host wins
    cycleOp(0, 4'h0, 8'h00, 0, 0, 1, 8'h77);      // R9 engine data load
    cycleOp(1, 4'h8, 8'h1C, 0, 0, 0, 0);          // R2 command strobe
    hostRd(4'h8);                                  // R3
    cycleOp(1, 4'hA, 8'h09, 0, 0, 0, 0);          // R8
    hostRd(4'hA);
    hostRd(4'hF);                                  // R4

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      if ($urandom_range(0, 7) == 0) engStatus = 8'($urandom);
      case (op)
        0, 1: cycleOp(1, 4'($urandom), 8'($urandom), 0, 0, 0, 0);
        2: cycleOp(1, 4'($urandom_range(0, 1) ? 0 : 8), 8'($urandom_range(0, 7)), 0, 0, 0, 0);
        3: cycleOp(0, 4'h0, 8'h00, 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        default: hostRd(4'($urandom));
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule